// File: doc/BRIEF.md
# Memory Region Fill Generator

This block writes a known data pattern into a region of memory so that a companion read checker can later confirm the region. Software sets a byte base, a byte end and a byte length. It also chooses whether the address offsets count up or follow a pseudo-random sequence, and whether the data counts up or is pseudo-random. A one-cycle `start` then launches the run. The block emits one write command and one write-data beat for every data word. It raises `done` once the last word has been accepted by both channels.

The byte quantities become word quantities by shifting right by log2 of the data width in bytes. The word offset is masked with one less than the span (end minus base, in words). The span must be a power of two for the wrap to cover the region as intended. All settings are captured at `start`, so later changes on the configuration inputs have no effect on a run in progress. A one-cycle `soft_clr` aborts a run or clears `done`.

Top module: `mem_fill_gen`

## Requirements
- R1: After `rst_n` is low at a clock edge, `done`, `cmd_valid` and `wd_valid` are 0.
- R2: For each word of a run, the command address is (`cfg_base` >> log2(DATA_W/8)) plus the masked offset. The run issues `cfg_len` >> log2(DATA_W/8) words. With DATA_W = 32, base 16 and length 64 fill word addresses 4 to 19.
- R3: With `cfg_rand_data` = 0, the word issued at position i of the run carries the value i, so the first word is 0.
- R4: The offset is masked with ((`cfg_end` − `cfg_base`) >> log2(DATA_W/8)) − 1, which must be a power of two minus one. A run longer than the span therefore wraps back to the base and overwrites earlier words, and no address outside the span is written.
- R5: With `cfg_rand_addr` = 1, the offset comes from a 32-bit Galois LFSR seeded with 1 at `start`, so its first offset is 1 masked by the span. The data still counts 0, 1, 2, … and so stays below the word count. Repeated addresses are allowed.
- R6: With `cfg_rand_data` = 1, the data comes from a Galois LFSR (taps 0x80200003, seed 1, value 1 on the first word). The words of a run are all different and do not count 0, 1, 2, ….
- R7: Each channel keeps its valid high and its payload stable until it is accepted. The address and data sources step, and the next word begins, only after both the command and the data beat of the current word are accepted, in the same cycle or in different cycles. Each word gets exactly one command and one data beat.
- R8: `done` rises in the cycle after the last word completes. It stays high, with both valids low, until the next `start` or `soft_clr`. A run with zero words raises `done` without issuing any beat.
- R9: `soft_clr` forces `done`, `cmd_valid` and `wd_valid` low from the next cycle. It takes priority over `start`.
- R10: A `start` while a run is in progress is ignored, together with any change of the configuration inputs.
- R11: Every command issued carries `cmd_we` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_clr | input | 1 | One-cycle clear of run and done |
| start | input | 1 | One-cycle launch of a run |
| cfg_base | input | ADDR_W | Region base in bytes |
| cfg_end | input | ADDR_W | Region end in bytes |
| cfg_len | input | LEN_W | Bytes to write |
| cfg_rand_addr | input | 1 | 1 = pseudo-random address offsets |
| cfg_rand_data | input | 1 | 1 = pseudo-random data |
| done | output | 1 | Run complete |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted |
| cmd_we | output | 1 | Write flag of the command |
| cmd_addr | output | ADDR_W | Word address of the command |
| wd_valid | output | 1 | Write data offered |
| wd_ready | input | 1 | Write data accepted |
| wd_data | output | DATA_W | Write data |

## Verification
Acceptance on the command channel and acceptance on the data channel can fall in the same cycle, or one can come ahead of the other by several cycles. The bench drives the two ready inputs from a shared cycle counter using different bit patterns, so both orders occur during a single run. It also runs a case with both readies held high, where every word completes in one cycle. In each case the run must issue exactly one beat per channel per word and leave the same memory image as the unstalled run. A second collision, a `start` arriving while a run is in progress, is judged the same way: the fill must be unchanged.

// File: rtl/mfg_pkg.sv
// Package: shared types for the memory region fill generator.
// Assumes: nothing beyond SystemVerilog 2017.
package mfg_pkg;

    // Run state of the fill sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_e;

endpackage

// File: rtl/mfg_src.sv
// Module: mfg_src
// Produces one test value per word: an up-counter or a Galois LFSR.
// The mode is captured at load, both generators restart at load and
// advance on step. Assumes SEED is nonzero and TAPS is maximal length.
module mfg_src #(
    parameter int          W    = 32,
    parameter logic [W-1:0] TAPS = W'(32'h80200003),
    parameter logic [W-1:0] SEED = W'(1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         rand_sel,
    output logic [W-1:0] value
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] lfsr_q;
    logic         sel_q;

    assign value = sel_q ? lfsr_q : cnt_q;

    // Restart on load, advance both generators on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lfsr_q <= SEED;
            sel_q  <= 1'b0;
        end else if (load) begin
            cnt_q  <= '0;
            lfsr_q <= SEED;
            sel_q  <= rand_sel;
        end else if (step) begin
            cnt_q  <= cnt_q + W'(1);
            lfsr_q <= (lfsr_q >> 1) ^ (lfsr_q[0] ? TAPS : '0);
        end
    end

    // LFSR never collapses to zero after a run starts (R6).
    p_lfsr_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q |-> lfsr_q != '0);

endmodule

// File: rtl/mfg_seq.sv
// Module: mfg_seq
// Sequences one command beat and one data beat per word. It records
// which channel has already been accepted and steps only once both are.
// Assumes the word count is presented at start and the block is idle then.
module mfg_seq
    import mfg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             start,
    input  logic [CNT_W-1:0] words,
    input  logic             cmd_ready,
    input  logic             wd_ready,
    output logic             cmd_valid,
    output logic             wd_valid,
    output logic             load,
    output logic             step,
    output logic             done
);

    run_state_e       state_q;
    logic [CNT_W-1:0] words_q;
    logic [CNT_W-1:0] idx_q;
    logic             cmd_sent_q;
    logic             wd_sent_q;
    logic             running;
    logic             cmd_fire;
    logic             wd_fire;

    assign running   = (state_q == ST_RUN);
    assign done      = (state_q == ST_DONE);
    assign cmd_valid = running && !cmd_sent_q;
    assign wd_valid  = running && !wd_sent_q;
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign wd_fire   = wd_valid && wd_ready;
    assign load      = start && !running && !soft_clr;
    assign step      = running && !soft_clr
                       && (cmd_sent_q || cmd_fire) && (wd_sent_q || wd_fire);

    // Run state, word index and per-channel accepted flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            words_q    <= '0;
            idx_q      <= '0;
            cmd_sent_q <= 1'b0;
            wd_sent_q  <= 1'b0;
        end else if (soft_clr) begin
            state_q    <= ST_IDLE;
            cmd_sent_q <= 1'b0;
            wd_sent_q  <= 1'b0;
        end else if (load) begin
            words_q    <= words;
            idx_q      <= '0;
            cmd_sent_q <= 1'b0;
            wd_sent_q  <= 1'b0;
            state_q    <= (words == '0) ? ST_DONE : ST_RUN;
        end else if (step) begin
            cmd_sent_q <= 1'b0;
            wd_sent_q  <= 1'b0;
            if (idx_q == words_q - CNT_W'(1)) state_q <= ST_DONE;
            else                              idx_q   <= idx_q + CNT_W'(1);
        end else if (running) begin
            if (cmd_fire) cmd_sent_q <= 1'b1;
            if (wd_fire)  wd_sent_q  <= 1'b1;
        end
    end

    // Offered command stays offered until taken (R7).
    p_cmd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready && !soft_clr |=> cmd_valid);
    // Offered data stays offered until taken (R7).
    p_wd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_valid && !wd_ready && !soft_clr |=> wd_valid);
    // Done persists until start or clear (R8).
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start && !soft_clr |=> done);
    // Clear silences both channels and done (R9).
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> !cmd_valid && !wd_valid && !done);
    // Start during a run keeps the run going (R10).
    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        running && start && !soft_clr && !step |=> running);

endmodule

// File: rtl/mem_fill_gen.sv
// Module: mem_fill_gen (top)
// Fills a memory region word by word over a command channel and a write
// data channel. Byte settings are turned into word settings and captured
// at start; the offset wraps with a mask taken from the span.
// Assumes DATA_W is a power-of-two multiple of 8 and the span a power of two.
module mem_fill_gen
    import mfg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_end,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_rand_addr,
    input  logic              cfg_rand_data,
    output logic              done,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_we,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wd_valid,
    input  logic              wd_ready,
    output logic [DATA_W-1:0] wd_data
);

    localparam int BYTES = DATA_W / 8;
    localparam int SHIFT = $clog2(BYTES);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] mask_q;
    logic [ADDR_W-1:0] addr_off;
    logic [LEN_W-1:0]  words;
    logic              load;
    logic              step;

    assign words  = cfg_len >> SHIFT;
    assign cmd_we = 1'b1;
    assign cmd_addr = base_q + (addr_off & mask_q);

    // Capture word base and wrap mask at the start of a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
        end else if (load) begin
            base_q <= cfg_base >> SHIFT;
            mask_q <= ((cfg_end - cfg_base) >> SHIFT) - ADDR_W'(1);
        end
    end

    mfg_seq #(.CNT_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .start     (start),
        .words     (words),
        .cmd_ready (cmd_ready),
        .wd_ready  (wd_ready),
        .cmd_valid (cmd_valid),
        .wd_valid  (wd_valid),
        .load      (load),
        .step      (step),
        .done      (done)
    );

    mfg_src #(.W(ADDR_W)) u_addr_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .rand_sel (cfg_rand_addr),
        .value    (addr_off)
    );

    mfg_src #(.W(DATA_W)) u_data_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .rand_sel (cfg_rand_data),
        .value    (wd_data)
    );

    // Commands stay inside the span from the base (R4).
    p_addr_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ((cmd_addr - base_q) & ~mask_q) == '0);
    // Stalled command keeps its address (R7).
    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready && !soft_clr |=> $stable(cmd_addr));
    // Stalled data keeps its value (R7).
    p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_valid && !wd_ready && !soft_clr |=> $stable(wd_data));

endmodule

// File: tb/mem_fill_gen_test.sv
// Bench: directed scenarios for mem_fill_gen, one task each, with a
// 64-word memory image rebuilt from the beats accepted on each channel.
module mem_fill_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int MW         = 64;
    localparam logic [31:0] BLANK = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [31:0] cfg_end = '0;
    logic [31:0] cfg_len = '0;
    logic        cfg_rand_addr = 1'b0;
    logic        cfg_rand_data = 1'b0;
    logic        done;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic        cmd_we;
    logic [31:0] cmd_addr;
    logic        wd_valid;
    logic        wd_ready = 1'b0;
    logic [31:0] wd_data;

    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    int          rdy_mode = 0;
    int          n_cmd = 0;
    int          n_dat = 0;
    int          we_bad = 0;
    logic [31:0] alog [MW];
    logic [31:0] dlog [MW];
    logic [31:0] mem  [MW];

    mem_fill_gen uut (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .start(start),
        .cfg_base(cfg_base), .cfg_end(cfg_end), .cfg_len(cfg_len),
        .cfg_rand_addr(cfg_rand_addr), .cfg_rand_data(cfg_rand_data),
        .done(done), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_we(cmd_we), .cmd_addr(cmd_addr), .wd_valid(wd_valid),
        .wd_ready(wd_ready), .wd_data(wd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Drive readies and log the beats that the next rising edge accepts.
    always @(negedge clk) begin
        cyc++;
        case (rdy_mode)
            0: begin cmd_ready = 1'b1; wd_ready = 1'b1; end
            1: begin cmd_ready = cyc[0]; wd_ready = (cyc % 3) == 0; end
            default: begin cmd_ready = 1'b0; wd_ready = 1'b0; end
        endcase
        if (cmd_valid && cmd_ready) begin
            if (n_cmd < MW) alog[n_cmd] = cmd_addr;
            if (cmd_we !== 1'b1) we_bad++;
            n_cmd++;
        end
        if (wd_valid && wd_ready) begin
            if (n_dat < MW) dlog[n_dat] = wd_data;
            n_dat++;
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, act cycles=%0d exp below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Configure, pulse start, wait for done, rebuild the memory image.
    task automatic run_fill(input logic [31:0] b, input logic [31:0] e,
                            input logic [31:0] l, input bit ra, input bit rd,
                            input int mode);
        @(negedge clk);
        for (int i = 0; i < MW; i++) mem[i] = BLANK;
        n_cmd = 0; n_dat = 0; we_bad = 0; rdy_mode = mode;
        cfg_base = b; cfg_end = e; cfg_len = l;
        cfg_rand_addr = ra; cfg_rand_data = rd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        rdy_mode = 0;
        for (int i = 0; i < n_cmd && i < MW; i++)
            if (alog[i] < MW) mem[alog[i]] = dlog[i];
    endtask

    task automatic t_reset;
        chk(done == 1'b0 && cmd_valid == 1'b0 && wd_valid == 1'b0, "R1",
            {29'd0, done, cmd_valid, wd_valid}, 32'd0);
    endtask

    task automatic t_seq_fill;
        run_fill(16, 80, 64, 1'b0, 1'b0, 0);
        chk(n_cmd == 16 && n_dat == 16, "R2", n_cmd, 16);
        for (int i = 0; i < 16; i++) chk(mem[4 + i] == i, "R3", mem[4 + i], i);
        chk(mem[3] == BLANK && mem[20] == BLANK, "R2", mem[20], BLANK);
        chk(we_bad == 0, "R11", we_bad, 0);
        tick(6);
        chk(done && !cmd_valid && !wd_valid && n_cmd == 16, "R8", n_cmd, 16);
    endtask

    task automatic t_stalled;
        run_fill(16, 80, 64, 1'b0, 1'b0, 1);
        chk(n_cmd == 16 && n_dat == 16, "R7", n_dat, 16);
        for (int i = 0; i < 16; i++) chk(alog[i] == 4 + i, "R7", alog[i], 4 + i);
        for (int i = 0; i < 16; i++) chk(mem[4 + i] == i, "R7", mem[4 + i], i);
    endtask

    task automatic t_wrap;
        run_fill(16, 48, 64, 1'b0, 1'b0, 0);
        chk(n_cmd == 16, "R4", n_cmd, 16);
        for (int i = 0; i < 8; i++) chk(mem[4 + i] == 8 + i, "R4", mem[4 + i], 8 + i);
        for (int i = 12; i < 20; i++) chk(mem[i] == BLANK, "R4", mem[i], BLANK);
    endtask

    task automatic t_rand_addr;
        int seq_hits;
        run_fill(16, 80, 64, 1'b1, 1'b0, 0);
        seq_hits = 0;
        chk(alog[0] == 5, "R5", alog[0], 5);
        for (int i = 0; i < 16; i++) begin
            chk(alog[i] >= 4 && alog[i] < 20, "R5", alog[i], 4);
            chk(dlog[i] == i && dlog[i] < 16, "R5", dlog[i], i);
            if (alog[i] == 4 + i) seq_hits++;
        end
        chk(seq_hits < 16, "R5", seq_hits, 0);
    endtask

    task automatic t_rand_data;
        int dups;
        run_fill(16, 80, 64, 1'b0, 1'b1, 0);
        dups = 0;
        for (int i = 0; i < 16; i++)
            for (int j = i + 1; j < 16; j++)
                if (dlog[i] == dlog[j]) dups++;
        chk(dups == 0, "R6", dups, 0);
        chk(dlog[0] == 32'd1 && dlog[1] == 32'h80200003, "R6", dlog[1], 32'h80200003);
        for (int i = 0; i < 16; i++) chk(alog[i] == 4 + i, "R6", alog[i], 4 + i);
    endtask

    task automatic t_zero_len;
        run_fill(0, 64, 0, 1'b0, 1'b0, 0);
        chk(done && n_cmd == 0 && n_dat == 0, "R8", n_cmd, 0);
    endtask

    task automatic t_clear;
        @(negedge clk);
        n_cmd = 0; rdy_mode = 2;
        cfg_base = 0; cfg_end = 64; cfg_len = 64;
        cfg_rand_addr = 0; cfg_rand_data = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        tick(3);
        chk(cmd_valid && wd_valid, "R9", {30'd0, cmd_valid, wd_valid}, 3);
        soft_clr = 1'b1; start = 1'b1;
        @(negedge clk);
        soft_clr = 1'b0; start = 1'b0;
        chk(!cmd_valid && !wd_valid && !done, "R9", {31'd0, cmd_valid}, 0);
        tick(3);
        chk(!cmd_valid && !done && n_cmd == 0, "R9", n_cmd, 0);
        rdy_mode = 0;
    endtask

    task automatic t_busy_start;
        @(negedge clk);
        for (int i = 0; i < MW; i++) mem[i] = BLANK;
        n_cmd = 0; n_dat = 0; rdy_mode = 1;
        cfg_base = 16; cfg_end = 80; cfg_len = 64;
        cfg_rand_addr = 0; cfg_rand_data = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        tick(5);
        cfg_base = 128; cfg_len = 32; cfg_rand_data = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        rdy_mode = 0;
        for (int i = 0; i < n_cmd && i < MW; i++)
            if (alog[i] < MW) mem[alog[i]] = dlog[i];
        chk(n_cmd == 16 && n_dat == 16, "R10", n_cmd, 16);
        for (int i = 0; i < 16; i++) chk(mem[4 + i] == i, "R10", mem[4 + i], i);
    endtask

    initial begin
        tick(3);
        t_reset;
        rst_n = 1'b1;
        tick(2);
        t_seq_fill;
        t_stalled;
        t_wrap;
        t_rand_addr;
        t_rand_data;
        t_zero_len;
        t_clear;
        t_busy_start;
        tick(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule